// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank State Tracking

This block watches the command pins of a four-bank DDR SDRAM at every rising clock edge and turns them into one decoded command per cycle. Besides the pin pattern it looks at the clock-enable level sampled at this edge and at the previous edge, which it remembers itself. It also looks at the bank-select pins and the multiplexed address bus. The result comes out one cycle later as a command code, the bank it targets, the row or column address it carries, the row currently open in that bank, and an auto-precharge flag.

Next to the decoder sits a table with one entry per bank. Each entry holds an open/closed bit and the row opened by the last activate. Two small counters are kept as well. One enforces the quiet gap after a mode-register load. The other tracks a read or write burst that closes its bank by itself when it ends. A command that the current state forbids raises the error flag in the same cycle as its decoded code, and it leaves the bank table and the counters untouched. The block is meant to sit beside a memory bus as a protocol monitor, or to act as the front end of a memory model.

Top module: `ddrcmd_tracker`

## Requirements
- R1: While chip select (`cs_n`) is high and clock enable was high at both this edge and the previous one, the command is a deselect, code 0, whatever the other pins show.
- R2: With `cs_n` low and clock enable high at both edges, the pins {`ras_n`,`cas_n`,`we_n`} decode as: 000 mode-register load (code 2), 001 refresh (see R3), 011 activate (6), 101 read (7), 100 write (8), 110 burst stop (9), 010 precharge (see R5), 111 no-op (1). A no-op or deselect never raises `err_o`.
- R3: Pins 001 with clock enable high then high give auto refresh (3). The same pins with clock enable going from high to low give self-refresh entry (4). Clock enable going from low to high gives self-refresh exit (5), whatever the pins show. Clock enable low at both edges gives no-op (1). The previous clock-enable level is taken as high after reset.
- R4: The bank index reported on `bank_o` is 0 for `ba`=00, 1 for `ba`=10 (only `ba[1]` high), 2 for `ba`=01 (only `ba[0]` high) and 3 for `ba`=11.
- R5: Activate reports the full 12-bit `addr` as the row. Read and write report `addr[9:0]` as the column, zero-extended, and `ap_o` = `addr[10]`. Precharge with `addr[10]` low is single-bank precharge (10). With `addr[10]` high it is precharge-all (11), `ba` is ignored and `bank_o` is 0. `ap_o` is 0 for every other command.
- R6: For a legal read, write or burst stop, `row_o` gives the row that the last accepted activate opened in the target bank.
- R7: Mode-register load, auto refresh and self-refresh entry raise `err_o` if any bank is open.
- R8: After an accepted mode-register load, any command other than no-op or deselect at either of the next 2 clock edges raises `err_o`.
- R9: A read, write or burst stop to a closed bank, or an activate to an open bank, raises `err_o`. A command that raises `err_o` changes no bank state and starts no counter.
- R10: An accepted read or write with auto precharge blocks every read and write, to any bank, at the next 2 edges. Its bank stays open through the second of those edges and counts as closed from the edge after.
- R11: An accepted single-bank precharge closes only its target bank. An accepted precharge-all closes every bank.
- R12: All outputs are registered, so the decode of the pins sampled at an edge appears right after that edge. After reset all outputs are 0, every bank is closed and no hold-off is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write-enable pin, active low |
| cke | input | 1 | Clock enable level at this edge |
| ba | input | 2 | Bank-select pins |
| addr | input | 12 | Multiplexed row/column/op-code address |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Target bank index |
| addr_o | output | 12 | Row (activate), column (read/write) or op code (mode load) |
| row_o | output | 12 | Open row of the target bank for read, write, burst stop |
| ap_o | output | 1 | Auto precharge requested |
| err_o | output | 1 | Command illegal in the current state |

## Verification
The decoder is swept over all sixteen combinations of chip select and the three strobe pins from an all-closed state. This separates every code point and shows which ones are refused against closed banks. Each of the four bank-select values opens and reads its own bank with its own row and column, which exposes any swap of the two bank bits or of the row and column fields. Directed sequences then place commands exactly at the edges where the mode-load gap and the auto-precharge burst end. The same command is issued one edge before the boundary and at it, so an off-by-one count shows up. Other sequences issue refused commands and then read back the open rows, so that a refused command that wrongly changes state is caught.

// File: rtl/ddrcmd_pkg.sv
`timescale 1ns/1ps
package ddrcmd_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL    = 4'd0,
        CMD_NOP      = 4'd1,
        CMD_MRS      = 4'd2,
        CMD_AREF     = 4'd3,
        CMD_SREF_IN  = 4'd4,
        CMD_SREF_OUT = 4'd5,
        CMD_ACT      = 4'd6,
        CMD_RD       = 4'd7,
        CMD_WR       = 4'd8,
        CMD_BST      = 4'd9,
        CMD_PRE      = 4'd10,
        CMD_PREA     = 4'd11
    } cmd_e;

    // {ras_n, cas_n, we_n} patterns with chip select low
    localparam logic [2:0] PIN_MRS = 3'b000;
    localparam logic [2:0] PIN_REF = 3'b001;
    localparam logic [2:0] PIN_PRE = 3'b010;
    localparam logic [2:0] PIN_ACT = 3'b011;
    localparam logic [2:0] PIN_WR  = 3'b100;
    localparam logic [2:0] PIN_RD  = 3'b101;
    localparam logic [2:0] PIN_BST = 3'b110;

    function automatic logic is_quiet(input cmd_e c);
        return (c == CMD_DESEL) || (c == CMD_NOP);
    endfunction

    function automatic logic is_column(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/ddrcmd_decode.sv
`timescale 1ns/1ps
module ddrcmd_decode
    import ddrcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke_prev,
    input  logic cke_now,
    input  logic ap_bit,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev) begin
            // clock was gated: only a rising enable means anything
            cmd = cke_now ? CMD_SREF_OUT : CMD_NOP;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                PIN_MRS: cmd = CMD_MRS;
                PIN_REF: cmd = cke_now ? CMD_AREF : CMD_SREF_IN;
                PIN_ACT: cmd = CMD_ACT;
                PIN_RD:  cmd = CMD_RD;
                PIN_WR:  cmd = CMD_WR;
                PIN_BST: cmd = CMD_BST;
                PIN_PRE: cmd = ap_bit ? CMD_PREA : CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddrcmd_bank_table.sv
`timescale 1ns/1ps
module ddrcmd_bank_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         open_en,
    input  logic [$clog2(BANKS)-1:0]     open_bank,
    input  logic [ROW_W-1:0]             open_row,
    input  logic                         shut_en,
    input  logic [$clog2(BANKS)-1:0]     shut_bank,
    input  logic                         shut_all,
    input  logic                         drain_en,
    input  logic [$clog2(BANKS)-1:0]     drain_bank,
    output logic [BANKS-1:0]             open_vec,
    output logic [BANKS*ROW_W-1:0]       row_flat
);

    localparam int BANK_W = $clog2(BANKS);

    for (genvar g = 0; g < BANKS; g++) begin : g_slot
        typedef struct packed {
            logic             open;
            logic [ROW_W-1:0] row;
        } slot_t;

        slot_t slot_d, slot_q;
        logic  hit_shut, hit_open;

        always_comb begin
            slot_d   = slot_q;
            hit_shut = shut_all
                     || (shut_en  && (shut_bank  == BANK_W'(g)))
                     || (drain_en && (drain_bank == BANK_W'(g)));
            hit_open = open_en && (open_bank == BANK_W'(g));
            if (hit_shut) begin
                slot_d.open = 1'b0;
            end
            if (hit_open) begin
                slot_d.open = 1'b1;
                slot_d.row  = open_row;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign open_vec[g]                  = slot_q.open;
        assign row_flat[g*ROW_W +: ROW_W]   = slot_q.row;
    end

endmodule

// File: rtl/ddrcmd_guard.sv
`timescale 1ns/1ps
module ddrcmd_guard #(
    parameter int BURST_CYCLES = 2,
    parameter int MRS_GAP      = 2,
    parameter int BANK_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_start,
    input  logic              ap_start,
    input  logic [BANK_W-1:0] ap_bank_in,
    input  logic              ap_cancel,
    output logic              mrs_busy,
    output logic              ap_busy,
    output logic              ap_done,
    output logic [BANK_W-1:0] ap_bank
);

    localparam int HOLD_W  = $clog2(MRS_GAP + 1);
    localparam int BURST_W = $clog2(BURST_CYCLES + 1);

    typedef struct packed {
        logic [HOLD_W-1:0]  hold;
        logic [BURST_W-1:0] burst;
        logic [BANK_W-1:0]  bank;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (g_q.hold != '0) begin
            g_d.hold = g_q.hold - HOLD_W'(1);
        end
        if (mrs_start) begin
            g_d.hold = HOLD_W'(MRS_GAP);
        end
        if (g_q.burst != '0) begin
            g_d.burst = g_q.burst - BURST_W'(1);
        end
        if (ap_cancel) begin
            g_d.burst = '0;
        end
        if (ap_start) begin
            g_d.burst = BURST_W'(BURST_CYCLES);
            g_d.bank  = ap_bank_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign mrs_busy = (g_q.hold != '0);
    assign ap_busy  = (g_q.burst != '0);
    assign ap_done  = (g_q.burst == BURST_W'(1));
    assign ap_bank  = g_q.bank;

endmodule

// File: rtl/ddrcmd_tracker.sv
`timescale 1ns/1ps
module ddrcmd_tracker
    import ddrcmd_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int COL_W        = 10,
    parameter int BA_W         = 2,
    parameter int AP_BIT       = 10,
    parameter int BURST_CYCLES = 2,
    parameter int MRS_GAP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [BA_W-1:0]   ba,
    input  logic [ROW_W-1:0]  addr,
    output logic [3:0]        cmd_o,
    output logic [BA_W-1:0]   bank_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              ap_o,
    output logic              err_o
);

    localparam int BANKS = 1 << BA_W;

    typedef struct packed {
        logic             cke_prev;
        logic [3:0]       cmd;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] addr;
        logic [ROW_W-1:0] row;
        logic             ap;
        logic             err;
    } out_t;

    out_t st_d, st_q;

    cmd_e                   cmd;
    logic [BA_W-1:0]        tgt;
    logic [BANKS-1:0]       open_vec;
    logic [BANKS*ROW_W-1:0] row_flat;
    logic                   tgt_open;
    logic [ROW_W-1:0]       tgt_row;
    logic                   err;
    logic                   ap_req;
    logic                   open_en, shut_en, shut_all;
    logic                   mrs_start, ap_start, ap_cancel;
    logic                   mrs_busy, ap_busy, ap_done;
    logic [BA_W-1:0]        ap_bank;
    logic                   cke_prev_q;

    // bank index is the bank-select bus with its bits in reverse order
    for (genvar i = 0; i < BA_W; i++) begin : g_bank_map
        assign tgt[i] = ba[BA_W-1-i];
    end

    ddrcmd_decode u_decode (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cke_prev (st_q.cke_prev),
        .cke_now  (cke),
        .ap_bit   (addr[AP_BIT]),
        .cmd      (cmd)
    );

    ddrcmd_bank_table #(
        .BANKS (BANKS),
        .ROW_W (ROW_W)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_en    (open_en),
        .open_bank  (tgt),
        .open_row   (addr),
        .shut_en    (shut_en),
        .shut_bank  (tgt),
        .shut_all   (shut_all),
        .drain_en   (ap_done),
        .drain_bank (ap_bank),
        .open_vec   (open_vec),
        .row_flat   (row_flat)
    );

    ddrcmd_guard #(
        .BURST_CYCLES (BURST_CYCLES),
        .MRS_GAP      (MRS_GAP),
        .BANK_W       (BA_W)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrs_start  (mrs_start),
        .ap_start   (ap_start),
        .ap_bank_in (tgt),
        .ap_cancel  (ap_cancel),
        .mrs_busy   (mrs_busy),
        .ap_busy    (ap_busy),
        .ap_done    (ap_done),
        .ap_bank    (ap_bank)
    );

    assign tgt_open = open_vec[tgt];
    assign tgt_row  = row_flat[tgt*ROW_W +: ROW_W];
    assign ap_req   = addr[AP_BIT];

    // legality of the command against the current state
    always_comb begin
        err = 1'b0;
        if (mrs_busy && !is_quiet(cmd)) begin
            err = 1'b1;
        end
        case (cmd)
            CMD_MRS, CMD_AREF, CMD_SREF_IN: if (|open_vec) err = 1'b1;
            CMD_ACT:                        if (tgt_open)  err = 1'b1;
            CMD_RD, CMD_WR:                 if (!tgt_open || ap_busy) err = 1'b1;
            CMD_BST:                        if (!tgt_open) err = 1'b1;
            default: ;
        endcase
    end

    // state actions taken only by accepted commands
    always_comb begin
        open_en   = !err && (cmd == CMD_ACT);
        shut_en   = !err && (cmd == CMD_PRE);
        shut_all  = !err && (cmd == CMD_PREA);
        mrs_start = !err && (cmd == CMD_MRS);
        ap_start  = !err && is_column(cmd) && ap_req;
        ap_cancel = ap_busy && (shut_all || (shut_en && (tgt == ap_bank)));
    end

    // registered output stage
    always_comb begin
        st_d          = st_q;
        st_d.cke_prev = cke;
        st_d.cmd      = cmd;
        st_d.err      = err;
        st_d.bank     = '0;
        st_d.addr     = '0;
        st_d.row      = '0;
        st_d.ap       = 1'b0;
        case (cmd)
            CMD_ACT: begin
                st_d.bank = tgt;
                st_d.addr = addr;
            end
            CMD_RD, CMD_WR: begin
                st_d.bank = tgt;
                st_d.addr = ROW_W'(addr[COL_W-1:0]);
                st_d.row  = tgt_open ? tgt_row : '0;
                st_d.ap   = ap_req;
            end
            CMD_BST: begin
                st_d.bank = tgt;
                st_d.row  = tgt_open ? tgt_row : '0;
            end
            CMD_PRE: begin
                st_d.bank = tgt;
            end
            CMD_MRS: begin
                st_d.addr = addr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cke_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cke_prev_q = st_q.cke_prev;
    assign cmd_o      = st_q.cmd;
    assign bank_o     = st_q.bank;
    assign addr_o     = st_q.addr;
    assign row_o      = st_q.row;
    assign ap_o       = st_q.ap;
    assign err_o      = st_q.err;

endmodule

// File: rtl/ddrcmd_tracker_chk.sv
`timescale 1ns/1ps
module ddrcmd_tracker_chk
    import ddrcmd_pkg::*;
#(
    parameter int BA_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            cke,
    input logic            cke_prev,
    input logic [3:0]      cmd_o,
    input logic [BA_W-1:0] bank_o,
    input logic            ap_o,
    input logic            err_o
);

    assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cke && cke_prev) |=> (cmd_o == CMD_DESEL));

    assert_quiet_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_NOP) || (cmd_o == CMD_DESEL)) |-> !err_o);

    assert_ap_only_column_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ap_o |-> ((cmd_o == CMD_RD) || (cmd_o == CMD_WR)));

    assert_mrs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_MRS) && !err_o) |=>
        ((cmd_o == CMD_NOP) || (cmd_o == CMD_DESEL) || err_o));

    assert_act_twice_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_ACT) && !err_o) |=>
        (!((cmd_o == CMD_ACT) && (bank_o == $past(bank_o))) || err_o));

    assert_ap_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (((cmd_o == CMD_RD) || (cmd_o == CMD_WR)) && ap_o && !err_o) |=>
        (!((cmd_o == CMD_RD) || (cmd_o == CMD_WR)) || err_o));

endmodule

bind ddrcmd_tracker ddrcmd_tracker_chk #(.BA_W(BA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .cke      (cke),
    .cke_prev (cke_prev_q),
    .cmd_o    (cmd_o),
    .bank_o   (bank_o),
    .ap_o     (ap_o),
    .err_o    (err_o)
);

// File: tb/ddrcmd_tracker_tb.sv
`timescale 1ns/1ps
module ddrcmd_tracker_tb_top;

    localparam logic [2:0] P_MRS = 3'b000;
    localparam logic [2:0] P_REF = 3'b001;
    localparam logic [2:0] P_PRE = 3'b010;
    localparam logic [2:0] P_ACT = 3'b011;
    localparam logic [2:0] P_WR  = 3'b100;
    localparam logic [2:0] P_RD  = 3'b101;
    localparam logic [2:0] P_BST = 3'b110;
    localparam logic [2:0] P_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n, cke;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [3:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [11:0] addr_o, row_o;
    logic        ap_o, err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ddrcmd_tracker dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cke    (cke),
        .ba     (ba),
        .addr   (addr),
        .cmd_o  (cmd_o),
        .bank_o (bank_o),
        .addr_o (addr_o),
        .row_o  (row_o),
        .ap_o   (ap_o),
        .err_o  (err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [2:0] p, input logic k,
                         input logic [1:0] b, input logic [11:0] a);
        @(negedge clk);
        cs_n = c;
        {ras_n, cas_n, we_n} = p;
        cke  = k;
        ba   = b;
        addr = a;
        @(posedge clk);
        #2;
    endtask

    task automatic op(input logic [2:0] p, input logic [1:0] b, input logic [11:0] a);
        drive(1'b0, p, 1'b1, b, a);
    endtask

    task automatic nop();
        drive(1'b0, P_NOP, 1'b1, 2'b00, 12'h000);
    endtask

    function automatic int exp_code(input logic c, input logic [2:0] p, input logic a10);
        if (c) return 0;
        case (p)
            P_MRS:   return 2;
            P_REF:   return 3;
            P_ACT:   return 6;
            P_RD:    return 7;
            P_WR:    return 8;
            P_BST:   return 9;
            P_PRE:   return a10 ? 11 : 10;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_bank(input logic [1:0] b);
        return int'({b[0], b[1]});
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cs_n = 1'b1; {ras_n, cas_n, we_n} = P_NOP; cke = 1'b1;
        ba = 2'b00; addr = 12'h000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 reset cmd", cmd_o, 0);
        chk("R12 reset err", err_o, 0);
        chk("R12 reset ap", ap_o, 0);
        chk("R12 reset addr", addr_o, 0);

        // R12: no hold-off pending, all banks closed
        op(P_ACT, 2'b00, 12'h001);
        chk("R12 first act accepted", err_o, 0);
        op(P_RD, 2'b10, 12'h000);
        chk("R12 bank1 closed after reset", err_o, 1);
        op(P_PRE, 2'b00, 12'h400);
        nop();

        // R1/R2/R9: sweep chip select and strobe pins from all-closed state
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 8; p++) begin
                logic [2:0] pp;
                int e_err;
                pp = 3'(p);
                drive(c[0], pp, 1'b1, 2'b00, 12'h000);
                chk(c == 1 ? "R1 deselect code" : "R2 decode code", cmd_o,
                    exp_code(c[0], pp, 1'b0));
                e_err = (c == 0 && (pp == P_RD || pp == P_WR || pp == P_BST)) ? 1 : 0;
                chk("R9 closed-bank legality", err_o, e_err);
                op(P_PRE, 2'b11, 12'h400);
                chk("R5 precharge-all code", cmd_o, 11);
                chk("R5 precharge-all bank ignored", bank_o, 0);
                nop();
                nop();
            end
        end

        // R4/R5/R6/R11: every bank value opens and reads its own bank
        for (int b = 0; b < 4; b++) begin
            logic [1:0]  bb;
            logic [11:0] row, col;
            bb  = 2'(b);
            row = 12'hA50 ^ 12'(b * 12'h111);
            col = 12'h800 | 12'(b * 12'h041 + 5);
            op(P_ACT, bb, row);
            chk("R4 act bank index", bank_o, exp_bank(bb));
            chk("R5 act row address", addr_o, row);
            chk("R9 act closed bank ok", err_o, 0);
            op(P_RD, bb, col);
            chk("R5 read column", addr_o, col & 12'h3FF);
            chk("R6 read open row", row_o, row);
            chk("R5 read no ap", ap_o, 0);
            chk("R4 read bank index", bank_o, exp_bank(bb));
            op(P_PRE, bb, 12'h000);
            chk("R11 single precharge code", cmd_o, 10);
            chk("R11 precharge bank", bank_o, exp_bank(bb));
            op(P_RD, bb, 12'h000);
            chk("R11 closed after precharge", err_o, 1);
            nop();
            chk("R9 error lasts one cycle", err_o, 0);
        end

        // open all four banks
        op(P_ACT, 2'b00, 12'h111);
        op(P_ACT, 2'b10, 12'h222);
        op(P_ACT, 2'b01, 12'h333);
        op(P_ACT, 2'b11, 12'h444);
        chk("R9 fourth act ok", err_o, 0);
        // R7: refused with banks open
        op(P_MRS, 2'b00, 12'h032);
        chk("R7 mode load with open banks", err_o, 1);
        op(P_REF, 2'b00, 12'h000);
        chk("R7 auto refresh code", cmd_o, 3);
        chk("R7 auto refresh with open banks", err_o, 1);
        drive(1'b0, P_REF, 1'b0, 2'b00, 12'h000);
        chk("R3 self-refresh entry code", cmd_o, 4);
        chk("R7 self-refresh entry with open banks", err_o, 1);
        drive(1'b1, P_NOP, 1'b1, 2'b00, 12'h000);
        chk("R3 self-refresh exit code", cmd_o, 5);
        // R9: refused activate keeps the old row
        op(P_ACT, 2'b00, 12'hFFF);
        chk("R9 act on open bank", err_o, 1);
        op(P_RD, 2'b00, 12'h000);
        chk("R9 refused act leaves row", row_o, 12'h111);
        op(P_BST, 2'b01, 12'h000);
        chk("R2 burst stop code", cmd_o, 9);
        chk("R6 burst stop row", row_o, 12'h333);
        // R11: single precharge closes only its bank
        op(P_PRE, 2'b10, 12'h000);
        op(P_RD, 2'b10, 12'h000);
        chk("R11 precharged bank closed", err_o, 1);
        op(P_RD, 2'b01, 12'h000);
        chk("R11 other bank still open", err_o, 0);
        chk("R11 other bank row", row_o, 12'h333);
        op(P_PRE, 2'b00, 12'h400);
        op(P_RD, 2'b00, 12'h000);
        chk("R11 precharge-all closes bank 0", err_o, 1);
        op(P_WR, 2'b11, 12'h000);
        chk("R11 precharge-all closes bank 3", err_o, 1);
        op(P_BST, 2'b01, 12'h000);
        chk("R9 burst stop to closed bank", err_o, 1);

        // R3: legal refresh variants with all banks closed
        op(P_REF, 2'b00, 12'h000);
        chk("R3 auto refresh idle", err_o, 0);
        drive(1'b0, P_REF, 1'b0, 2'b00, 12'h000);
        chk("R3 self-refresh entry idle", err_o, 0);
        drive(1'b0, P_ACT, 1'b0, 2'b00, 12'h000);
        chk("R3 gated clock is no-op", cmd_o, 1);
        drive(1'b1, P_NOP, 1'b1, 2'b00, 12'h000);
        chk("R3 exit code", cmd_o, 5);
        chk("R3 exit legal", err_o, 0);

        // R8: mode-load hold-off window
        op(P_MRS, 2'b00, 12'h032);
        chk("R8 mode load accepted", err_o, 0);
        chk("R8 mode load op code", addr_o, 12'h032);
        op(P_ACT, 2'b00, 12'h010);
        chk("R8 command at gap edge 1", err_o, 1);
        op(P_ACT, 2'b00, 12'h010);
        chk("R8 command at gap edge 2", err_o, 1);
        op(P_ACT, 2'b00, 12'h010);
        chk("R8 command after gap", err_o, 0);
        op(P_PRE, 2'b00, 12'h400);
        op(P_MRS, 2'b00, 12'h021);
        nop();
        chk("R8 no-op in gap legal", err_o, 0);
        nop();
        op(P_ACT, 2'b00, 12'h123);
        chk("R8 act after quiet gap", err_o, 0);

        // R10: read with auto precharge
        op(P_ACT, 2'b10, 12'h456);
        op(P_RD, 2'b00, 12'h47F);
        chk("R5 read ap flag", ap_o, 1);
        chk("R10 ap read accepted", err_o, 0);
        chk("R5 ap read column", addr_o, 12'h07F);
        op(P_RD, 2'b10, 12'h000);
        chk("R10 other-bank read blocked", err_o, 1);
        op(P_ACT, 2'b00, 12'h321);
        chk("R10 bank open through burst end", err_o, 1);
        op(P_ACT, 2'b00, 12'h321);
        chk("R10 bank closed after burst", err_o, 0);
        op(P_RD, 2'b10, 12'h005);
        chk("R10 read after burst legal", err_o, 0);
        chk("R6 bank1 row", row_o, 12'h456);
        // R10: write with auto precharge
        op(P_WR, 2'b10, 12'h400);
        chk("R10 ap write accepted", err_o, 0);
        chk("R5 write ap flag", ap_o, 1);
        op(P_WR, 2'b00, 12'h000);
        chk("R10 write blocked during burst", err_o, 1);
        nop();
        op(P_RD, 2'b10, 12'h000);
        chk("R10 write-ap bank closed", err_o, 1);
        op(P_RD, 2'b00, 12'h000);
        chk("R10 other bank kept", err_o, 0);
        chk("R6 bank0 new row", row_o, 12'h321);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule